// File: doc/BRIEF.md
# Binary64 to Integer Converter with Selectable Overflow Policy

This unit turns one IEEE binary64 value into a 64-bit integer register result. It can return the result as signed or unsigned, 32-bit or 64-bit. A mode code chooses how values that do not fit, and NaNs, are handled. One option clamps to the limits and maps NaN to the most negative value. A second option clamps the same way but maps NaN to zero. A third option wraps the rounded integer modulo 2^N, as a scripting-language integer conversion does. The same mode code can also force round-toward-zero in place of the rounding mode that the caller supplies.

Each conversion takes one cycle. The operands are sampled on a clock edge while `in_valid` is high. The result, a destination write enable and five status flags are registered and appear, together with `out_valid`, at the next edge. Overflow is reported only when the caller enables it. When invalid-operation trapping is enabled, a conversion that raises the invalid flag or the signalling-NaN flag does not write its destination.

Top module: `f2i_conv`

## Requirements
- R1: `int_type` selects the output format: 0 is signed 32-bit, with the result sign-extended from bit 31 to 64 bits; 1 is unsigned 32-bit, with the upper 32 bits zero; 2 is signed 64-bit; 3 is unsigned 64-bit.
- R2: Rounding to an integer uses round-toward-zero when `cvt_mode[0]` is 1. Otherwise `round_mode` decides: 00 is nearest with ties to even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity.
- R3: With `cvt_mode[2:1]`=00, a NaN gives the format minimum. A rounded value above the format maximum gives the maximum, and one below the format minimum gives the minimum. Any other value gives the rounded integer, and a negative zero gives 0.
- R4: With `cvt_mode[2:1]`=01, a NaN gives 0. Out-of-range values clamp exactly as in R3.
- R5: With `cvt_mode[2:1]`=10, a NaN, an infinity or a rounded magnitude of 2^128 or more gives 0. Any other value gives the low N bits (N = 32 or 64) of the two's complement rounded integer, extended as in R1.
- R6: `cvt_mode` 110 and 111 raise `illegal_flag`, hold `wr_en` low and clear the overflow, inexact, invalid and signalling-NaN flags.
- R7: `ovf_flag` is set when `ovf_en` is 1 and the source is NaN or infinite, or when its rounded value cannot be represented in the selected format. It is 0 whenever `ovf_en` is 0.
- R8: `inexact_flag` is set when the integer result is not numerically equal to the source. This happens when the source has a nonzero fraction or when the condition of R7 holds.
- R9: `cvi_flag` is set on the condition of R7, whatever the value of `ovf_en`. `snan_flag` is set when the source is a NaN whose quiet bit (bit 51) is 0.
- R10: `wr_en` is 1 for a legal mode unless `inv_trap_en` is 1 and `cvi_flag` or `snan_flag` is raised. Inexactness alone never blocks the write.
- R11: Outputs appear with `out_valid` one cycle after `in_valid`. Reset, and any cycle without an input, leave `out_valid`, `wr_en` and all flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| src_bits | input | 64 | Binary64 source value |
| int_type | input | 2 | Integer format select |
| cvt_mode | input | 3 | Policy in bits 2:1, force-truncate in bit 0 |
| round_mode | input | 2 | Rounding mode used when truncation is not forced |
| ovf_en | input | 1 | Enables overflow reporting |
| inv_trap_en | input | 1 | Blocks the write when the conversion is invalid |
| out_valid | output | 1 | Result registers hold a new conversion |
| result | output | 64 | Integer result |
| wr_en | output | 1 | Destination write enable |
| ovf_flag | output | 1 | Overflow |
| inexact_flag | output | 1 | Result differs from the source |
| cvi_flag | output | 1 | Invalid conversion |
| snan_flag | output | 1 | Signalling NaN source |
| illegal_flag | output | 1 | Reserved mode code used |

## Verification
The first group of vectors holds the format and policy fixed and sweeps all four rounding modes over halfway and fractional sources, including a denormal. This separates ties-to-even from other tie handling and shows that the force-truncate bit overrides `round_mode`. The same out-of-range, NaN and infinite sources are then run under each policy. This separates min-saturation from zero-NaN saturation from modular wrap, and values just past 2^32 or near 2^70 show that wrap keeps the low bits and does not clamp. The exact limits -2^63 and 2^63, negative zero, and negative inputs to unsigned formats test the range comparison at its edges. Enable-off and trap-on variants separate flag raising from flag reporting and write blocking.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int MAN_W  = 52;
  localparam int BIAS   = 1023;

  typedef enum logic [1:0] {
    POL_SAT_MIN  = 2'b00,
    POL_SAT_ZERO = 2'b01,
    POL_WRAP     = 2'b10,
    POL_RESV     = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_ZERO  = 2'b01,
    RM_UP    = 2'b10,
    RM_DOWN  = 2'b11
  } rmode_e;
endpackage

// File: rtl/f2i_decode.sv
module f2i_decode
  import f2i_pkg::*;
#(
  parameter int WIDE_W = 128
) (
  input  logic [FP_W-1:0]   src_bits,
  input  logic [1:0]        rm,
  output logic              sign,
  output logic              is_nan,
  output logic              is_snan,
  output logic              is_inf,
  output logic              huge,
  output logic              frac_nz,
  output logic [WIDE_W-1:0] mag
);
  localparam int E_W    = EXP_W + 1;
  localparam int EXT_W  = 2*MAN_W + 3;
  localparam logic [E_W-1:0] SH_BIAS  = E_W'(BIAS + MAN_W);
  localparam logic [E_W-1:0] HUGE_SH  = E_W'(WIDE_W - MAN_W);
  localparam logic [E_W-1:0] DROP_SH  = E_W'(MAN_W + 3);

  logic [EXP_W-1:0]  e_raw;
  logic [MAN_W-1:0]  frac;
  logic [MAN_W:0]    mant;
  logic [E_W-1:0]    exp_u, lsh, rsh;
  logic [EXT_W-1:0]  ext;
  logic [WIDE_W-1:0] ip;
  logic              grd, stk, inc;

  assign sign    = src_bits[FP_W-1];
  assign e_raw   = src_bits[FP_W-2 -: EXP_W];
  assign frac    = src_bits[MAN_W-1:0];
  assign is_nan  = (&e_raw) && (|frac);
  assign is_inf  = (&e_raw) && !(|frac);
  assign is_snan = is_nan && !frac[MAN_W-1];
  assign mant    = {|e_raw, frac};
  assign exp_u   = {1'b0, e_raw};
  assign lsh     = exp_u - SH_BIAS;
  assign rsh     = SH_BIAS - exp_u;

  always_comb begin
    ip   = '0;
    grd  = 1'b0;
    stk  = 1'b0;
    huge = 1'b0;
    ext  = '0;
    if (&e_raw) begin
      huge = 1'b0;
    end else if (exp_u >= SH_BIAS) begin
      huge = (lsh >= HUGE_SH);
      ip   = WIDE_W'(mant) << lsh;
    end else if (rsh >= DROP_SH) begin
      stk = |mant;
    end else begin
      ext = {mant, {(MAN_W+2){1'b0}}} >> rsh;
      ip  = WIDE_W'(ext[EXT_W-1 -: MAN_W+1]);
      grd = ext[MAN_W+1];
      stk = |ext[MAN_W:0];
    end
  end

  always_comb begin
    unique case (rmode_e'(rm))
      RM_NEAR: inc = grd && (stk || ip[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = !sign && (grd || stk);
      default: inc = sign && (grd || stk);
    endcase
  end

  assign frac_nz = grd || stk;
  assign mag     = ip + WIDE_W'(inc);
endmodule

// File: rtl/f2i_range.sv
module f2i_range
  import f2i_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int WIDE_W = 128
) (
  input  logic              sign,
  input  logic              is_nan,
  input  logic              is_inf,
  input  logic              huge,
  input  logic [WIDE_W-1:0] mag,
  input  logic [1:0]        int_type,
  input  policy_e           pol,
  output logic              fits,
  output logic [INT_W-1:0]  value
);
  localparam int HALF_W = INT_W / 2;
  localparam logic [WIDE_W-1:0] ONE = WIDE_W'(1);

  logic              wide_fmt, uns;
  int                nbits;
  logic [WIDE_W-1:0] max_pos, max_neg, sval;
  logic [INT_W-1:0]  max_v, min_v, pre;

  assign wide_fmt = int_type[1];
  assign uns      = int_type[0];
  assign nbits    = wide_fmt ? INT_W : HALF_W;

  always_comb begin
    max_pos = uns ? ((ONE << nbits) - ONE) : ((ONE << (nbits - 1)) - ONE);
    max_neg = uns ? '0 : (ONE << (nbits - 1));
    max_v   = max_pos[INT_W-1:0];
    min_v   = INT_W'(~max_neg + ONE);
    sval    = sign ? (~mag + ONE) : mag;
    fits    = !is_nan && !is_inf && !huge &&
              (sign ? (mag <= max_neg) : (mag <= max_pos));
  end

  always_comb begin
    if (pol == POL_WRAP) begin
      pre = (is_nan || is_inf || huge) ? '0 : sval[INT_W-1:0];
    end else if (fits) begin
      pre = sval[INT_W-1:0];
    end else if (is_nan) begin
      pre = (pol == POL_SAT_ZERO) ? '0 : min_v;
    end else begin
      pre = sign ? min_v : max_v;
    end
  end

  generate
    if (INT_W > HALF_W) begin : g_ext
      always_comb begin
        if (wide_fmt)
          value = pre;
        else if (uns)
          value = {{(INT_W-HALF_W){1'b0}}, pre[HALF_W-1:0]};
        else
          value = {{(INT_W-HALF_W){pre[HALF_W-1]}}, pre[HALF_W-1:0]};
      end
    end
  endgenerate
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int WIDE_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  src_bits,
  input  logic [1:0]       int_type,
  input  logic [2:0]       cvt_mode,
  input  logic [1:0]       round_mode,
  input  logic             ovf_en,
  input  logic             inv_trap_en,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             wr_en,
  output logic             ovf_flag,
  output logic             inexact_flag,
  output logic             cvi_flag,
  output logic             snan_flag,
  output logic             illegal_flag
);
  logic              sgn, nan_s, snan_s, inf_s, huge_s, fr_nz, fits;
  logic [WIDE_W-1:0] mag;
  logic [INT_W-1:0]  value;
  logic [1:0]        eff_rm;
  policy_e           pol;
  logic              bad, ill, cvi_d, sn_d;

  assign eff_rm = cvt_mode[0] ? RM_ZERO : round_mode;
  assign pol    = policy_e'(cvt_mode[2:1]);

  f2i_decode #(.WIDE_W(WIDE_W)) u_dec (
    .src_bits(src_bits), .rm(eff_rm), .sign(sgn), .is_nan(nan_s),
    .is_snan(snan_s), .is_inf(inf_s), .huge(huge_s), .frac_nz(fr_nz),
    .mag(mag)
  );

  f2i_range #(.INT_W(INT_W), .WIDE_W(WIDE_W)) u_rng (
    .sign(sgn), .is_nan(nan_s), .is_inf(inf_s), .huge(huge_s), .mag(mag),
    .int_type(int_type), .pol(pol), .fits(fits), .value(value)
  );

  assign ill   = (pol == POL_RESV);
  assign bad   = !fits;
  assign cvi_d = !ill && bad;
  assign sn_d  = !ill && snan_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      wr_en        <= 1'b0;
      ovf_flag     <= 1'b0;
      inexact_flag <= 1'b0;
      cvi_flag     <= 1'b0;
      snan_flag    <= 1'b0;
      illegal_flag <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      if (in_valid)
        result <= value;
      wr_en        <= in_valid && !ill && !(inv_trap_en && (cvi_d || sn_d));
      ovf_flag     <= in_valid && ovf_en && cvi_d;
      inexact_flag <= in_valid && !ill && (bad || fr_nz);
      cvi_flag     <= in_valid && cvi_d;
      snan_flag    <= in_valid && sn_d;
      illegal_flag <= in_valid && ill;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int INT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       int_type,
  input logic [2:0]       cvt_mode,
  input logic             ovf_en,
  input logic             inv_trap_en,
  input logic             out_valid,
  input logic [INT_W-1:0] result,
  input logic             wr_en,
  input logic             ovf_flag,
  input logic             inexact_flag,
  input logic             cvi_flag,
  input logic             snan_flag,
  input logic             illegal_flag
);
  localparam int HALF_W = INT_W / 2;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && !ovf_flag && !cvi_flag && !illegal_flag)); // R11
  AST_S32_SIGNEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int_type == 2'd0) |=> (result[INT_W-1:HALF_W] == {(INT_W-HALF_W){result[HALF_W-1]}})); // R1
  AST_U32_ZEROEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int_type == 2'd1) |=> (result[INT_W-1:HALF_W] == '0)); // R1
  AST_ILLEGAL_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    illegal_flag |-> (!wr_en && !cvi_flag && !inexact_flag && !snan_flag)); // R6
  AST_RESV_MODE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cvt_mode[2:1] == 2'b11) |=> illegal_flag); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ovf_en) |=> !ovf_flag); // R7
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (inexact_flag && cvi_flag)); // R8
  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (rst)
    snan_flag |-> cvi_flag); // R9
  AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inv_trap_en) |=> !(wr_en && (cvi_flag || snan_flag))); // R10
endmodule

bind f2i_conv f2i_conv_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .int_type(int_type),
  .cvt_mode(cvt_mode), .ovf_en(ovf_en), .inv_trap_en(inv_trap_en),
  .out_valid(out_valid), .result(result), .wr_en(wr_en),
  .ovf_flag(ovf_flag), .inexact_flag(inexact_flag), .cvi_flag(cvi_flag),
  .snan_flag(snan_flag), .illegal_flag(illegal_flag)
);

// File: tb/f2i_conv_test.sv
module f2i_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_bits = '0;
  logic [1:0]  int_type = '0;
  logic [2:0]  cvt_mode = '0;
  logic [1:0]  round_mode = '0;
  logic        ovf_en = 1'b0;
  logic        inv_trap_en = 1'b0;
  logic        out_valid, wr_en, ovf_flag, inexact_flag, cvi_flag, snan_flag, illegal_flag;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [63:0] res;
    logic        chk_res;
    logic        ovf, inx, cvi, sn, wr, ill;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  f2i_conv uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_bits(src_bits),
    .int_type(int_type), .cvt_mode(cvt_mode), .round_mode(round_mode),
    .ovf_en(ovf_en), .inv_trap_en(inv_trap_en), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .ovf_flag(ovf_flag),
    .inexact_flag(inexact_flag), .cvi_flag(cvi_flag), .snan_flag(snan_flag),
    .illegal_flag(illegal_flag)
  );

  task automatic drive(input logic [63:0] s, input logic [1:0] t, input logic [2:0] m,
                       input logic [1:0] r, input logic oe, input logic ie,
                       input logic [63:0] er, input logic cr,
                       input logic eo, input logic ex, input logic ec,
                       input logic es, input logic ew, input logic el,
                       input string tag);
    exp_t e;
    @(negedge clk);
    src_bits = s; int_type = t; cvt_mode = m; round_mode = r;
    ovf_en = oe; inv_trap_en = ie; in_valid = 1'b1;
    e = '{res: er, chk_res: cr, ovf: eo, inx: ex, cvi: ec, sn: es, wr: ew, ill: el};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected output: actual out_valid=1 expected 0");
      end else begin
        exp_t  e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        if ((e.chk_res && result !== e.res) || ovf_flag !== e.ovf ||
            inexact_flag !== e.inx || cvi_flag !== e.cvi || snan_flag !== e.sn ||
            wr_en !== e.wr || illegal_flag !== e.ill) begin
          fails++;
          $display("FAIL %s: actual res=%h ovf=%b inx=%b cvi=%b snan=%b wr=%b ill=%b expected res=%h ovf=%b inx=%b cvi=%b snan=%b wr=%b ill=%b",
                   tg, result, ovf_flag, inexact_flag, cvi_flag, snan_flag, wr_en, illegal_flag,
                   e.res, e.ovf, e.inx, e.cvi, e.sn, e.wr, e.ill);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || ovf_flag !== 1'b0 ||
        cvi_flag !== 1'b0 || inexact_flag !== 1'b0 || illegal_flag !== 1'b0) begin
      fails++;
      $display("FAIL %s: actual valid=%b wr=%b ovf=%b cvi=%b inx=%b ill=%b expected all 0",
               tag, out_valid, wr_en, ovf_flag, cvi_flag, inexact_flag, illegal_flag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    check_idle("R11 reset state");
    @(negedge clk) rst = 1'b0;
    check_idle("R11 idle after reset");

    // rounding modes, signed 64, min-saturate policy
    drive($realtobits(3.5),  2, 3'b000, 2'b00, 1, 0, 64'd4, 1, 0,1,0,0,1,0, "R2 nearest 3.5");
    drive($realtobits(2.5),  2, 3'b000, 2'b00, 1, 0, 64'd2, 1, 0,1,0,0,1,0, "R2 tie even 2.5");
    drive($realtobits(0.5),  2, 3'b000, 2'b00, 1, 0, 64'd0, 1, 0,1,0,0,1,0, "R2 tie even 0.5");
    drive($realtobits(-2.5), 2, 3'b000, 2'b10, 1, 0, 64'hFFFFFFFFFFFFFFFE, 1, 0,1,0,0,1,0, "R2 ceil -2.5");
    drive($realtobits(-2.5), 2, 3'b000, 2'b11, 1, 0, 64'hFFFFFFFFFFFFFFFD, 1, 0,1,0,0,1,0, "R2 floor -2.5");
    drive($realtobits(2.7),  2, 3'b001, 2'b10, 1, 0, 64'd2, 1, 0,1,0,0,1,0, "R2 forced trunc 2.7");
    drive($realtobits(2.7),  2, 3'b000, 2'b01, 1, 0, 64'd2, 1, 0,1,0,0,1,0, "R2 rm trunc 2.7");
    drive(64'h0000000000000001, 2, 3'b000, 2'b10, 1, 0, 64'd1, 1, 0,1,0,0,1,0, "R2 ceil denormal");
    // formats
    drive($realtobits(-1.0), 0, 3'b000, 2'b00, 1, 0, 64'hFFFFFFFFFFFFFFFF, 1, 0,0,0,0,1,0, "R1 s32 -1");
    drive($realtobits(3.0e9), 1, 3'b000, 2'b00, 1, 0, 64'h00000000B2D05E00, 1, 0,0,0,0,1,0, "R1 u32 3e9");
    // saturation and NaN policies
    drive($realtobits(3.0e9), 0, 3'b000, 2'b00, 1, 0, 64'h000000007FFFFFFF, 1, 1,1,1,0,1,0, "R3 s32 clamp max");
    drive($realtobits(-5.0),  1, 3'b000, 2'b00, 1, 0, 64'd0, 1, 1,1,1,0,1,0, "R3 u32 clamp min");
    drive(64'h8000000000000000, 1, 3'b000, 2'b00, 1, 0, 64'd0, 1, 0,0,0,0,1,0, "R3 negative zero");
    drive(64'hC3E0000000000000, 2, 3'b000, 2'b00, 1, 0, 64'h8000000000000000, 1, 0,0,0,0,1,0, "R3 exact -2^63");
    drive(64'h43E0000000000000, 2, 3'b000, 2'b00, 1, 0, 64'h7FFFFFFFFFFFFFFF, 1, 1,1,1,0,1,0, "R3 2^63 clamp");
    drive(64'h7FF8000000000000, 2, 3'b000, 2'b00, 1, 0, 64'h8000000000000000, 1, 1,1,1,0,1,0, "R3 NaN to min");
    drive(64'h7FF8000000000000, 2, 3'b010, 2'b00, 1, 0, 64'd0, 1, 1,1,1,0,1,0, "R4 NaN to zero");
    drive($realtobits(1.0e30), 3, 3'b010, 2'b00, 1, 0, 64'hFFFFFFFFFFFFFFFF, 1, 1,1,1,0,1,0, "R4 u64 clamp max");
    // modular policy
    drive($realtobits(4294967301.0), 0, 3'b100, 2'b00, 1, 0, 64'd5, 1, 1,1,1,0,1,0, "R5 wrap 2^32+5");
    drive($realtobits(4294967295.0), 0, 3'b100, 2'b00, 1, 0, 64'hFFFFFFFFFFFFFFFF, 1, 1,1,1,0,1,0, "R5 wrap s32 2^32-1");
    drive($realtobits(-1.5), 1, 3'b101, 2'b00, 1, 0, 64'h00000000FFFFFFFF, 1, 1,1,1,0,1,0, "R5 wrap u32 -1.5");
    drive(64'h4450000000000004, 2, 3'b100, 2'b00, 1, 0, 64'h0000000000100000, 1, 1,1,1,0,1,0, "R5 wrap 2^70+2^20");
    drive(64'h7FF0000000000000, 2, 3'b100, 2'b00, 1, 0, 64'd0, 1, 1,1,1,0,1,0, "R5 wrap infinity");
    drive(64'h4C70000000000000, 3, 3'b100, 2'b00, 1, 0, 64'd0, 1, 1,1,1,0,1,0, "R5 wrap 2^200");
    // illegal modes
    drive($realtobits(1.0), 2, 3'b110, 2'b00, 1, 0, 64'd0, 0, 0,0,0,0,0,1, "R6 mode 110");
    drive(64'h7FF0000000000001, 2, 3'b111, 2'b00, 1, 1, 64'd0, 0, 0,0,0,0,0,1, "R6 mode 111 sNaN");
    // enables and trapping
    drive($realtobits(1.0e30), 2, 3'b000, 2'b00, 0, 0, 64'h7FFFFFFFFFFFFFFF, 1, 0,1,1,0,1,0, "R7 R9 ovf disabled");
    drive($realtobits(1.25), 2, 3'b000, 2'b00, 1, 1, 64'd1, 1, 0,1,0,0,1,0, "R8 R10 inexact writes");
    drive(64'h7FF0000000000001, 0, 3'b000, 2'b00, 1, 1, 64'hFFFFFFFF80000000, 1, 1,1,1,1,0,0, "R9 R10 sNaN trapped");
    drive($realtobits(-3.0e9), 0, 3'b000, 2'b00, 0, 1, 64'hFFFFFFFF80000000, 1, 0,1,1,0,0,0, "R10 range trapped");
    @(negedge clk) in_valid = 1'b0;
    check_idle("R11 idle after burst");
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 missing outputs: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule